// File: doc/BRIEF.md
# Nine-Bit Address-Filtering Serial Receiver

This block receives asynchronous serial frames that carry nine data bits and separates address frames from data frames on a shared multidrop line. The line is sampled on a 16x oversampling tick supplied from outside. Each bit is decided by a vote over three samples around the bit centre. The first eight bits received form the data byte, and the ninth bit is kept in a status bit.

A small register interface gives software one control/status register and one receive data register. Software sets a filter-enable bit for address filtering. While the filter is enabled, only frames whose ninth bit is one (address frames) raise the receive flag and update the registers. Data frames meant for other nodes are dropped without a trace. The receive flag drives the interrupt output and stays set until software clears it.

Top module: `mp9_uart_rx`

## Requirements
- R1: After reset, the control/status register (address 0) and the data register (address 1) both read 0, and `rx_irq` is low.
- R2: A frame is a low start bit, eight data bits sent least significant bit first, a ninth bit, and a high stop bit. Each bit lasts 16 `rx_tick` pulses. An accepted frame loads its byte into the data register and its ninth bit into status bit 2. A later accepted frame overwrites both.
- R3: With the filter-enable bit (control/status bit 0) clear, every frame with a high stop bit sets the receive flag (control/status bit 1) and is accepted.
- R4: With the filter-enable bit set, only a frame whose ninth bit is 1 sets the flag. A frame whose ninth bit is 0 leaves the flag, the data register and status bit 2 unchanged.
- R5: Each bit takes the majority of its samples 7, 8 and 9. One sample of the three at the wrong level does not change the bit that is received.
- R6: A start bit that reads high at its vote point is treated as a glitch. The receiver returns to idle without setting the flag or changing the data. A frame that follows is received normally.
- R7: A frame whose stop bit is voted low is discarded. The flag and the data register stay unchanged.
- R8: The flag stays set until a write to address 0 with bit 1 at 0. A write with bit 1 at 1 leaves it set. `rx_irq` equals the flag at all times.
- R9: Writes to address 1 do not change the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_tick | input | 1 | Oversampling tick, 16 pulses per bit |
| rx_in | input | 1 | Serial receive line, idle high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control/status, 1 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| rx_irq | output | 1 | Receive interrupt, equal to the receive flag |

## Verification
The flag and the data register change one clock after the tick that carries the stop bit's ninth sample. Counted from the line, this is two synchroniser clocks plus one sample later. The bench therefore sends each frame in full and then about twelve idle samples before it reads any result. That gap lies well past this point and also lets a discarded frame's low stop bit run out as a rejected start. Register reads are combinational and are sampled one time step after the address changes at a falling edge. A write takes effect at the next rising edge, so its effect is read at the following falling edge.

// File: rtl/mp9_rx_pkg.sv
// Shared definitions for the nine-bit receiver: state encoding and
// register map constants. Assumes a one-bit register address.
package mp9_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

    localparam logic ADDR_CSR  = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    localparam int CSR_FILT  = 0;
    localparam int CSR_FLAG  = 1;
    localparam int CSR_NINTH = 2;

endpackage

// File: rtl/mp9_rx_sync.sv
// Line synchroniser: brings the asynchronous serial input into the clock
// domain through STAGES flops, preset to the idle (high) level on reset.
// STAGES of 0 passes the line straight through (input already synchronous).
module mp9_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] chain;

            // Shift the line through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end

            assign q = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/mp9_rx_vote.sv
// Three-sample majority voter. Captures the line at the two sample points
// just before the voting point; at the voting point (MID+1) the output
// combines them with the live line. Assumes cnt counts ticks within a bit.
module mp9_rx_vote #(
    parameter int OVERSAMPLE = 16,
    localparam int CNT_W     = $clog2(OVERSAMPLE),
    localparam int MID       = OVERSAMPLE / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic             line,
    output logic             vote
);

    logic samp_lo;
    logic samp_mid;

    // Hold the early and centre samples of the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_lo  <= 1'b1;
            samp_mid <= 1'b1;
        end else if (tick) begin
            if (cnt == CNT_W'(MID - 1)) samp_lo  <= line;
            if (cnt == CNT_W'(MID))     samp_mid <= line;
        end
    end

    // Two of three decide the bit.
    always_comb begin
        vote = (samp_lo & samp_mid) | (samp_lo & line) | (samp_mid & line);
    end

endmodule

// File: rtl/mp9_rx_frame.sv
// Frame engine: detects a start edge, checks the start bit at its vote
// point, shifts in WORD_BITS bits LSB first and votes the stop bit.
// Emits a one-clock done pulse with the word and the stop verdict at the
// stop bit's vote point, then returns to idle so a following start edge
// is caught. Assumes the line is already synchronised.
module mp9_rx_frame #(
    parameter int OVERSAMPLE = 16,
    parameter int WORD_BITS  = 9,
    localparam int CNT_W     = $clog2(OVERSAMPLE),
    localparam int IDX_W     = $clog2(WORD_BITS),
    localparam int DECIDE    = OVERSAMPLE / 2 + 1,
    localparam int LAST      = OVERSAMPLE - 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 line,
    output logic                 done,
    output logic                 stop_ok,
    output logic [WORD_BITS-1:0] word
);

    import mp9_rx_pkg::*;

    rx_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [WORD_BITS-1:0] shreg;
    logic               vote;
    logic               at_decide;
    logic               at_last;

    mp9_rx_vote #(
        .OVERSAMPLE(OVERSAMPLE)
    ) u_vote (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .cnt  (cnt),
        .line (line),
        .vote (vote)
    );

    assign at_decide = (cnt == CNT_W'(DECIDE));
    assign at_last   = (cnt == CNT_W'(LAST));

    // Sequence one frame bit by bit on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            cnt   <= CNT_W'(1);
                        end
                    end
                    ST_START: begin
                        if (at_decide && vote) begin
                            state <= ST_IDLE;
                        end else if (at_last) begin
                            state <= ST_DATA;
                            cnt   <= '0;
                            idx   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (at_decide) begin
                            shreg <= {vote, shreg[WORD_BITS-1:1]};
                        end
                        if (at_last) begin
                            cnt <= '0;
                            if (idx == IDX_W'(WORD_BITS - 1)) begin
                                state <= ST_STOP;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (at_decide) begin
                            done    <= 1'b1;
                            stop_ok <= vote;
                            state   <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign word = shreg;

endmodule

// File: rtl/mp9_uart_rx.sv
// Top of the nine-bit address-filtering receiver. Holds the filter-enable
// control bit, the sticky receive flag, the ninth-bit status and the data
// register; applies the acceptance rule to each completed frame.
// Assumes DATA_BITS + 1 frame bits and DATA_BITS <= REG_W.
module mp9_uart_rx #(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_BITS   = 8,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_tick,
    input  logic             rx_in,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             rx_irq
);

    import mp9_rx_pkg::*;

    localparam int WORD_BITS = DATA_BITS + 1;

    logic                 line_s;
    logic                 frm_done;
    logic                 frm_stop_ok;
    logic [WORD_BITS-1:0] frm_word;
    logic                 filt_q;
    logic                 flag_q;
    logic                 ninth_q;
    logic [DATA_BITS-1:0] data_q;
    logic                 accept;
    logic                 csr_wr;
    logic                 unused_wdata;

    mp9_rx_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rx_in),
        .q    (line_s)
    );

    mp9_rx_frame #(
        .OVERSAMPLE(OVERSAMPLE),
        .WORD_BITS (WORD_BITS)
    ) u_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (rx_tick),
        .line   (line_s),
        .done   (frm_done),
        .stop_ok(frm_stop_ok),
        .word   (frm_word)
    );

    // Acceptance rule: good stop bit, and ninth bit set when filtering.
    always_comb begin
        accept = frm_done && frm_stop_ok && (!filt_q || frm_word[WORD_BITS-1]);
        csr_wr = reg_wr && (reg_addr == ADDR_CSR);
    end

    assign unused_wdata = ^reg_wdata;

    // Control bit, sticky flag and received-frame registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q  <= 1'b0;
            flag_q  <= 1'b0;
            ninth_q <= 1'b0;
            data_q  <= '0;
        end else begin
            if (csr_wr) begin
                filt_q <= reg_wdata[CSR_FILT];
            end
            if (accept) begin
                flag_q  <= 1'b1;
                ninth_q <= frm_word[WORD_BITS-1];
                data_q  <= frm_word[DATA_BITS-1:0];
            end else if (csr_wr && !reg_wdata[CSR_FLAG]) begin
                flag_q <= 1'b0;
            end
        end
    end

    // Read multiplexer for the two registers.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_CSR) begin
            reg_rdata[CSR_FILT]  = filt_q;
            reg_rdata[CSR_FLAG]  = flag_q;
            reg_rdata[CSR_NINTH] = ninth_q;
        end else begin
            reg_rdata[DATA_BITS-1:0] = data_q;
        end
    end

    assign rx_irq = flag_q;

endmodule

// File: rtl/mp9_uart_rx_chk.sv
// Property checker for the nine-bit receiver, bound into every instance
// of the top module. Observes ports and the frame engine's outputs.
module mp9_uart_rx_chk #(
    parameter int DATA_BITS = 8,
    parameter int REG_W     = 8,
    localparam int WORD_BITS = DATA_BITS + 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr,
    input logic                 reg_addr,
    input logic [REG_W-1:0]     reg_wdata,
    input logic [REG_W-1:0]     reg_rdata,
    input logic                 rx_irq,
    input logic                 frm_done,
    input logic                 frm_stop_ok,
    input logic [WORD_BITS-1:0] frm_word,
    input logic                 filt_q,
    input logic                 ninth_q,
    input logic [DATA_BITS-1:0] data_q
);

    import mp9_rx_pkg::*;

    AST_FLAG_RISES_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(frm_done)); // R2

    AST_OPEN_FILTER_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_stop_ok && !filt_q) |=> rx_irq); // R3

    AST_FILTER_DROPS_DATA_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && filt_q && !frm_word[WORD_BITS-1]) |=> ($stable(data_q) && $stable(ninth_q))); // R4

    AST_BAD_STOP_DISCARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_stop_ok) |=> $stable(data_q)); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && !(reg_wr && reg_addr == ADDR_CSR && !reg_wdata[CSR_FLAG])) |=> rx_irq); // R8

    AST_IRQ_MATCHES_CSR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_CSR) |-> (rx_irq == reg_rdata[CSR_FLAG])); // R8

    AST_DATA_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_DATA && !frm_done) |=> $stable(data_q)); // R9

endmodule

bind mp9_uart_rx mp9_uart_rx_chk #(
    .DATA_BITS(DATA_BITS),
    .REG_W    (REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .rx_irq     (rx_irq),
    .frm_done   (frm_done),
    .frm_stop_ok(frm_stop_ok),
    .frm_word   (frm_word),
    .filt_q     (filt_q),
    .ninth_q    (ninth_q),
    .data_q     (data_q)
);

// File: tb/mp9_uart_rx_test.sv
// Self-checking bench for the nine-bit receiver: sweeps data bytes, both
// ninth-bit values and both filter settings, then targets vote, glitch,
// stop-bit and register corner cases. One tick every second clock.
`timescale 1ns/1ps
module mp9_uart_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rx_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic done_flag = 1'b0;

    logic       exp_filt = 1'b0;
    logic       exp_flag = 1'b0;
    logic       exp_ninth = 1'b0;
    logic [7:0] exp_data = 8'h00;

    mp9_uart_rx uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_tick  (rx_tick),
        .rx_in    (rx_in),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .rx_irq   (rx_irq)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done_flag) begin
            done_flag = 1'b1;
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One oversampling period: line level v, tick in the first clock.
    task automatic put(input logic v);
        @(negedge clk);
        rx_in   = v;
        rx_tick = 1'b1;
        @(negedge clk);
        rx_tick = 1'b0;
    endtask

    // Send a frame; flip_k selects the bit (0 start, 1..8 data, 9 ninth,
    // 10 stop) and flip_j the sample within it that is inverted.
    task automatic send(input logic [8:0] w, input logic stop, input int flip_k, input int flip_j);
        for (int k = 0; k < 11; k++) begin
            logic lvl;
            if (k == 0) lvl = 1'b0;
            else if (k == 10) lvl = stop;
            else lvl = w[k-1];
            for (int j = 0; j < 16; j++) begin
                put((k == flip_k && j == flip_j) ? ~lvl : lvl);
            end
        end
        for (int i = 0; i < 12; i++) put(1'b1);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        check({req, " irq"}, int'(rx_irq), int'(exp_flag));
        rd(1'b0, v);
        check({req, " csr"}, int'(v), int'({5'b0, exp_ninth, exp_flag, exp_filt}));
        rd(1'b1, v);
        check({req, " data"}, int'(v), int'(exp_data));
    endtask

    task automatic frame(input logic [8:0] w, input logic stop, input int fk, input int fj, input string req);
        send(w, stop, fk, fj);
        if (stop && (!exp_filt || w[8])) begin
            exp_flag  = 1'b1;
            exp_ninth = w[8];
            exp_data  = w[7:0];
        end
        check_all(req);
    endtask

    task automatic set_filter(input logic f);
        wr(1'b0, {7'b0, f});
        exp_filt = f;
        exp_flag = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_all("R1");

        // R3 / R4 / R2: sweep filter, ninth bit and data bytes
        for (int f = 0; f < 2; f++) begin
            set_filter(f[0]);
            for (int n = 0; n < 2; n++) begin
                for (int i = 0; i < 64; i++) begin
                    logic [7:0] d;
                    d = 8'((i * 4) + (i % 4));
                    frame({n[0], d}, 1'b1, -1, 0, (f == 1) ? "R4 R2" : "R3 R2");
                    set_filter(f[0]);
                end
            end
        end

        // R5: one wrong sample among 7, 8, 9 is outvoted
        set_filter(1'b0);
        for (int j = 7; j < 10; j++) begin
            frame({1'b1, 8'hA5}, 1'b1, 4, j, "R5 data bit");
            set_filter(1'b0);
            frame({1'b0, 8'h3C}, 1'b1, 9, j, "R5 ninth bit");
            set_filter(1'b0);
        end
        set_filter(1'b1);
        frame({1'b0, 8'h77}, 1'b1, 9, 8, "R5 R4 filtered ninth");

        // R6: short low pulse on the line is a glitch
        set_filter(1'b0);
        frame({1'b1, 8'h5A}, 1'b1, -1, 0, "R6 setup");
        set_filter(1'b0);
        for (int i = 0; i < 4; i++) put(1'b0);
        for (int i = 0; i < 24; i++) put(1'b1);
        check_all("R6 glitch");
        frame({1'b0, 8'hC3}, 1'b1, -1, 0, "R6 after glitch");

        // R7: low stop bit discards the frame
        set_filter(1'b0);
        frame({1'b1, 8'h99}, 1'b0, -1, 0, "R7");
        frame({1'b1, 8'h12}, 1'b1, 10, 8, "R7 R5 stop vote");

        // R8: flag sticky, write with bit 1 set keeps it, overwrite by new frame
        wr(1'b0, 8'h02);
        check_all("R8 keep");
        frame({1'b0, 8'h34}, 1'b1, -1, 0, "R8 R2 overwrite");
        wr(1'b0, 8'h00);
        exp_flag = 1'b0;
        check_all("R8 clear");

        // R9: data register is read-only
        wr(1'b1, 8'hEE);
        check_all("R9");

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule